// File: doc/BRIEF.md
# Averaged Voltage-Drop and Temperature-Slope Termination Detector

This block watches a stream of converter results for two channels: cell voltage and temperature-sense voltage. On a fixed sample period it takes a burst of evenly spaced measurements and averages them into one sample per channel. The cell burst is 32 measurements long in peak-detect mode and 16 long otherwise. The temperature burst is always 16 measurements. A longer burst spans a whole mains cycle, so line ripple averages out.

Each cell sample is compared with the highest in-window sample seen since the start of fast charge. A large enough fall raises the voltage termination flag. Each temperature sample is compared with the sample taken two periods before it. A large enough fall in the sense voltage, which means the cell is warming, raises the slope termination flag.

The charge controller asserts `clear` when fast charge starts. It supplies the hold-off expiry and the window comparator results, and it reads the two sticky flags.

Top module: `vdrop_term_det`

## Requirements
- R1: After reset, and in the cycle after `clear` has been high for one clock, both flags are low, the running maximum and the temperature history are empty, and the sample period restarts at tick 0 in the first cycle with `clear` low.
- R2: A period lasts PERIOD_TICKS clocks. Measurements are taken at ticks 0, SPACE_TICKS, 2*SPACE_TICKS and so on, 32 in total, and samples are evaluated at tick 32*SPACE_TICKS. The flags change only at that evaluation.
- R3: With `vmode` = 2'b10 (peak-detect), the cell sample is floor(sum/32) of all 32 measurements. In every other mode it is floor(sum/16) of the first 16 measurements. The temperature sample is always floor(sum/16) of the first 16 measurements.
- R4: With `vmode` = 2'b01 (negative-delta), `vdrop_term` sets when the running maximum minus the current cell sample is at least NDV_DROP LSBs.
- R5: With `vmode` = 2'b10, `vdrop_term` sets when that difference is at least PVD_DROP LSBs.
- R6: With `vmode` = 2'b00 or 2'b11, `vdrop_term` never sets.
- R7: A cell sample taken while `cell_win_ok` is low is not tested and does not update the running maximum.
- R8: While `holdoff_done` is low, `vdrop_term` cannot set, but in-window samples still update the running maximum. The hold-off does not suppress the temperature-slope test.
- R9: `tslope_term` sets when the temperature sample from two periods earlier minus the current one is at least SLOPE_DROP LSBs. The test needs two earlier samples since `clear`.
- R10: While `temp_win_ok` is low, the slope test is skipped, but the history still shifts.
- R11: Once set, each flag stays high until `clear` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Start-of-fast-charge clear, synchronous |
| adc_valid | input | 1 | Conversion result strobe |
| adc_chan | input | 1 | Channel of the result: 0 = cell, 1 = temperature |
| adc_data | input | DW | Conversion result |
| vmode | input | 2 | 00/11 voltage test off, 01 negative-delta, 10 peak-detect |
| holdoff_done | input | 1 | High once the voltage hold-off has expired |
| cell_win_ok | input | 1 | Cell voltage lies inside the valid window for the drop test |
| temp_win_ok | input | 1 | Temperature voltage lies inside the slope-test window |
| vdrop_term | output | 1 | Sticky voltage-drop termination flag |
| tslope_term | output | 1 | Sticky temperature-slope termination flag |

## Verification
A corrupted running maximum or a wrong averaging count shows at the ports only when the drop threshold is crossed. It appears as a missing or early `vdrop_term` at the end of a period, so the stimulus places samples just below and exactly at each threshold, and mixes two values inside one burst. A stale temperature history fires `tslope_term` one period early or late, and the two-earlier comparison is probed with a staircase. Since flags may only move at the evaluation tick, the outputs are also checked one tick before it, to catch a flag that rises at the wrong time.

// File: rtl/vdrop_term_det.sv
module vdrop_term_det #(
  parameter int DW           = 12,
  parameter int PERIOD_TICKS = 34_000_000,
  parameter int SPACE_TICKS  = 57,
  parameter int NDV_DROP     = 12,
  parameter int PVD_DROP     = 6,
  parameter int SLOPE_DROP   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          adc_valid,
  input  logic          adc_chan,
  input  logic [DW-1:0] adc_data,
  input  logic [1:0]    vmode,
  input  logic          holdoff_done,
  input  logic          cell_win_ok,
  input  logic          temp_win_ok,
  output logic          vdrop_term,
  output logic          tslope_term
);
  localparam int MEAS_MAX  = 32;
  localparam int MEAS_TEMP = 16;
  localparam int EVAL_TICK = MEAS_MAX * SPACE_TICKS;
  localparam int TW        = $clog2(PERIOD_TICKS + 1);
  localparam int SW        = $clog2(SPACE_TICKS + 1);
  localparam logic [1:0] MODE_NDV = 2'b01;
  localparam logic [1:0] MODE_PVD = 2'b10;

  logic [TW-1:0]   tick_cnt;
  logic [SW-1:0]   space_cnt;
  logic [5:0]      meas_idx;
  logic [DW-1:0]   cell_lat, temp_lat;
  logic [DW+4:0]   cell_acc;
  logic [DW+3:0]   temp_acc;
  logic [DW-1:0]   vmax, t_h1, t_h2;
  logic            vmax_ok;
  logic [1:0]      t_n;

  wire period_end = (tick_cnt == TW'(PERIOD_TICKS - 1));
  wire take       = (space_cnt == '0) && (meas_idx < 6'd32);
  wire eval       = (tick_cnt == TW'(EVAL_TICK));
  wire peak       = (vmode == MODE_PVD);
  wire vdrop_on   = (vmode == MODE_NDV) || peak;
  wire [5:0] ncell = peak ? 6'd32 : 6'd16;

  wire [DW-1:0] cell_avg = peak ? cell_acc[DW+4:5] : cell_acc[DW+3:4];
  wire [DW-1:0] temp_avg = temp_acc[DW+3:4];
  wire [DW-1:0] vthr     = peak ? DW'(PVD_DROP) : DW'(NDV_DROP);

  wire vfall = vmax_ok && (vmax > cell_avg) && ((vmax - cell_avg) >= vthr);
  wire tfall = (t_n == 2'd2) && (t_h2 > temp_avg) && ((t_h2 - temp_avg) >= DW'(SLOPE_DROP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt  <= '0;
      space_cnt <= '0;
      meas_idx  <= '0;
    end else if (clear || period_end) begin
      tick_cnt  <= '0;
      space_cnt <= '0;
      meas_idx  <= '0;
    end else begin
      tick_cnt  <= tick_cnt + 1'b1;
      space_cnt <= (space_cnt == SW'(SPACE_TICKS - 1)) ? '0 : space_cnt + 1'b1;
      if (take) meas_idx <= meas_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_lat <= '0;
      temp_lat <= '0;
    end else if (adc_valid) begin
      if (adc_chan) temp_lat <= adc_data;
      else          cell_lat <= adc_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_acc <= '0;
      temp_acc <= '0;
    end else if (clear || period_end) begin
      cell_acc <= '0;
      temp_acc <= '0;
    end else if (take) begin
      if (meas_idx < ncell)             cell_acc <= cell_acc + (DW+5)'(cell_lat);
      if (meas_idx < 6'(MEAS_TEMP))     temp_acc <= temp_acc + (DW+4)'(temp_lat);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vmax        <= '0;
      vmax_ok     <= 1'b0;
      t_h1        <= '0;
      t_h2        <= '0;
      t_n         <= '0;
      vdrop_term  <= 1'b0;
      tslope_term <= 1'b0;
    end else if (clear) begin
      vmax        <= '0;
      vmax_ok     <= 1'b0;
      t_h1        <= '0;
      t_h2        <= '0;
      t_n         <= '0;
      vdrop_term  <= 1'b0;
      tslope_term <= 1'b0;
    end else if (eval) begin
      if (cell_win_ok) begin
        if (vdrop_on && holdoff_done && vfall) vdrop_term <= 1'b1;
        if (!vmax_ok || cell_avg > vmax) vmax <= cell_avg;
        vmax_ok <= 1'b1;
      end
      if (temp_win_ok && tfall) tslope_term <= 1'b1;
      t_h2 <= t_h1;
      t_h1 <= temp_avg;
      if (t_n != 2'd2) t_n <= t_n + 1'b1;
    end
  end

  p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    meas_idx <= 6'd32);

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!vdrop_term && !tslope_term && !vmax_ok && t_n == 2'd0));

  p_rise_at_eval_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vdrop_term) || $rose(tslope_term)) |-> $past(eval));

  p_vgate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vdrop_term) |-> $past(vdrop_on && holdoff_done && cell_win_ok));

  p_twin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tslope_term) |-> $past(temp_win_ok));

  p_vsticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vdrop_term && !clear) |=> vdrop_term);

  p_tsticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tslope_term && !clear) |=> tslope_term);
endmodule

// File: tb/vdrop_term_det_tb_top.sv
module vdrop_term_det_tb_top;
  localparam int DW = 12;
  localparam int PER = 80;
  localparam int SP = 2;
  localparam int EVAL = 32 * SP;

  typedef struct { logic [1:0] flags; string tag; } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic adc_valid = 1'b0;
  logic adc_chan = 1'b0;
  logic [DW-1:0] adc_data = '0;
  logic [1:0] vmode = 2'b00;
  logic holdoff_done = 1'b0;
  logic cell_win_ok = 1'b0;
  logic temp_win_ok = 1'b0;
  logic vdrop_term, tslope_term;

  always #5 clk = ~clk;

  vdrop_term_det #(.DW(DW), .PERIOD_TICKS(PER), .SPACE_TICKS(SP),
                   .NDV_DROP(12), .PVD_DROP(6), .SLOPE_DROP(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .adc_valid(adc_valid),
    .adc_chan(adc_chan), .adc_data(adc_data), .vmode(vmode),
    .holdoff_done(holdoff_done), .cell_win_ok(cell_win_ok),
    .temp_win_ok(temp_win_ok), .vdrop_term(vdrop_term), .tslope_term(tslope_term));

  int checks = 0, errors = 0;
  int tb_tick = -1;
  exp_t exp_q[$];
  logic [1:0] prev_exp = 2'b00;
  int cur_cell, cur_temp, vmax, th1, th2, hn;
  bit vok, ev, et;

  task automatic chk(logic [1:0] act, logic [1:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual {vdrop,tslope}=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  // monitor: compares flags one tick before evaluation and at period end
  initial begin
    forever begin
      @(negedge clk); #1;
      if (tb_tick == EVAL - 1)
        chk({vdrop_term, tslope_term}, prev_exp, "R2 flags unchanged before evaluation");
      if (tb_tick == PER - 1 && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk({vdrop_term, tslope_term}, e.flags, e.tag);
        prev_exp = e.flags;
      end
    end
  end

  task automatic load(bit ch, int v);
    @(negedge clk);
    adc_valid = 1'b1; adc_chan = ch; adc_data = DW'(v);
  endtask

  task automatic begin_group(int c, int t);
    @(negedge clk);
    tb_tick = -1;
    clear = 1'b1;
    load(1'b0, c);
    load(1'b1, t);
    @(negedge clk);
    adc_valid = 1'b0;
    #1 chk({vdrop_term, tslope_term}, 2'b00, "R1 flags low after clear");
    cur_cell = c; cur_temp = t;
    vok = 0; vmax = 0; hn = 0; th1 = 0; th2 = 0; ev = 0; et = 0;
    prev_exp = 2'b00;
  endtask

  task automatic run_period(int mode, bit hold, bit cw, bit tw, int mid,
                            int nc, int nt, string tag);
    int avg;
    exp_t e;
    avg = (mode == 2 && mid >= 0) ? (cur_cell + mid) / 2 : cur_cell;
    if (cw) begin
      if (vok && (mode == 1 || mode == 2) && hold && (vmax - avg) >= (mode == 2 ? 6 : 12)) ev = 1;
      if (!vok || avg > vmax) vmax = avg;
      vok = 1;
    end
    if (hn == 2 && tw && (th2 - cur_temp) >= 16) et = 1;
    th2 = th1; th1 = cur_temp;
    if (hn < 2) hn++;
    e.flags = {ev, et}; e.tag = tag;
    exp_q.push_back(e);
    for (int t = 0; t < PER; t++) begin
      @(negedge clk);
      tb_tick = t;
      if (t == 0) begin
        clear = 1'b0; vmode = 2'(mode); holdoff_done = hold;
        cell_win_ok = cw; temp_win_ok = tw;
      end
      if (t == 31 && mid >= 0) begin adc_valid = 1'b1; adc_chan = 1'b0; adc_data = DW'(mid); end
      if (t == 32) adc_valid = 1'b0;
      if (t == PER - 3) begin adc_valid = 1'b1; adc_chan = 1'b0; adc_data = DW'(nc); end
      if (t == PER - 2) begin adc_valid = 1'b1; adc_chan = 1'b1; adc_data = DW'(nt); end
      if (t == PER - 1) adc_valid = 1'b0;
    end
    cur_cell = nc; cur_temp = nt;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 chk({vdrop_term, tslope_term}, 2'b00, "R1 flags low in reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1 chk({vdrop_term, tslope_term}, 2'b00, "R1 flags low after reset");

    // negative-delta threshold and stickiness
    begin_group(2000, 1500);
    run_period(1, 1, 1, 1, -1, 2010, 1500, "R4 first sample");
    run_period(1, 1, 1, 1, -1, 2005, 1500, "R4 rising");
    run_period(1, 1, 1, 1, -1, 1998, 1500, "R4 drop 5 below max");
    run_period(1, 1, 1, 1, -1, 2100, 1500, "R4 drop 12 fires");
    run_period(1, 1, 1, 1, -1, 2100, 1500, "R11 voltage flag sticky");

    // peak-detect: 32-measurement average and 6 LSB threshold
    begin_group(2000, 1500);
    run_period(2, 1, 1, 1, -1, 2000, 1500, "R5 first sample");
    run_period(2, 1, 1, 1, 2020, 2005, 1500, "R3 peak averages 32 measurements");
    run_period(2, 1, 1, 1, -1, 2004, 1500, "R5 drop 5 holds");
    run_period(2, 1, 1, 1, -1, 2004, 1500, "R5 drop 6 fires");

    // negative-delta ignores second half of burst
    begin_group(2000, 1500);
    run_period(1, 1, 1, 1, -1, 2000, 1500, "R3 first sample");
    run_period(1, 1, 1, 1, 1900, 2000, 1500, "R3 negative-delta averages first 16");

    // disabled modes
    begin_group(2000, 1500);
    run_period(0, 1, 1, 1, -1, 1900, 1500, "R6 mode 00");
    run_period(0, 1, 1, 1, -1, 1800, 1500, "R6 mode 00 large drop");
    run_period(3, 1, 1, 1, -1, 1800, 1500, "R6 mode 11 large drop");

    // hold-off
    begin_group(2000, 1500);
    run_period(1, 0, 1, 1, -1, 2050, 1500, "R8 hold-off first");
    run_period(1, 0, 1, 1, -1, 2000, 1500, "R8 max tracked in hold-off");
    run_period(1, 0, 1, 1, -1, 2040, 1500, "R8 drop suppressed");
    run_period(1, 1, 1, 1, -1, 2038, 1500, "R8 max kept from hold-off");
    run_period(1, 1, 1, 1, -1, 2038, 1500, "R8 fires after hold-off");

    // cell window
    begin_group(2000, 1500);
    run_period(1, 1, 1, 1, -1, 2300, 1500, "R7 first sample");
    run_period(1, 1, 0, 1, -1, 1995, 1500, "R7 out-of-window high ignored");
    run_period(1, 1, 1, 1, -1, 1900, 1500, "R7 max not raised");
    run_period(1, 1, 0, 1, -1, 1988, 1500, "R7 out-of-window low not tested");
    run_period(1, 1, 1, 1, -1, 1988, 1500, "R7 in-window fires");

    // temperature slope, needs two earlier samples, not held off
    begin_group(2000, 1500);
    run_period(0, 0, 1, 1, -1, 2000, 1480, "R9 first temp");
    run_period(0, 0, 1, 1, -1, 2000, 1470, "R9 one earlier sample only");
    run_period(0, 0, 1, 1, -1, 2000, 1470, "R9 fires during hold-off");
    run_period(0, 0, 1, 1, -1, 2000, 1470, "R11 slope flag sticky");

    // slope threshold boundary
    begin_group(2000, 1500);
    run_period(0, 1, 1, 1, -1, 2000, 1500, "R9 stair 1");
    run_period(0, 1, 1, 1, -1, 2000, 1485, "R9 stair 2");
    run_period(0, 1, 1, 1, -1, 2000, 1484, "R9 drop 15 holds");
    run_period(0, 1, 1, 1, -1, 2000, 1484, "R9 drop 16 fires");

    // temperature window
    begin_group(2000, 1500);
    run_period(0, 1, 1, 1, -1, 2000, 1500, "R10 first");
    run_period(0, 1, 1, 1, -1, 2000, 1400, "R10 second");
    run_period(0, 1, 1, 0, -1, 2000, 1400, "R10 out of window no test");
    run_period(0, 1, 1, 1, -1, 2000, 1400, "R10 history shifted, fires");

    begin_group(2000, 1500);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule